// File: doc/BRIEF.md
# Early-Late Phase-Picking Bit Selector

This block recovers burst-mode serial data one bit at a time without any preamble. Upstream circuitry samples the incoming waveform at four fixed phases of a bit-rate clock: on the reference edge, at the expected transition point that opens the bit, a quarter bit before the reference edge and a quarter bit after it. The block receives those four samples once per bit, with a strobe. It remembers the reference sample of the previous bit and compares the three samples around the opening transition. From that comparison it decides whether the reference edge is early or late against the data, or whether no decision is possible.

The decision steers a one-bit select register. The select register chooses which of the two quarter-offset sample streams is the recovered bit. The two candidate points sit a quarter bit either side of the nominal bit centre, so at least one of them always falls inside the data eye. A decision made on a bit already steers that same bit, so the block locks onto the first transition after a phase step. It needs no preamble, no start-of-burst pattern and no reset between bursts. Registered status flags and a saturating run-length counter of transition-free bits accompany each output bit.

Top module: `phase_pick_sel`

## Requirements
- R1: After a synchronous active-high reset, `sel` is 0 (pre-centre stream), `dout`, `dout_vld`, all four flags and `run_len` are 0, and the stored previous bit is 0.
- R2: Let P be the stored previous bit, M be `smp_mid` and C be `smp_ref`. A valid bit with P != M and M == C is late. `flag_late` goes high with the output, `sel` becomes 0, and `dout` is that bit's `smp_pre`.
- R3: A valid bit with P == M and M != C is early. `flag_early` goes high, `sel` becomes 1, and `dout` is that bit's `smp_post`.
- R4: A valid bit with P == M == C has no transition. `flag_idle` goes high, `sel` keeps its value, and `dout` is the sample of the stream that the held `sel` names (0 = `smp_pre`, 1 = `smp_post`).
- R5: A valid bit with P == C and M != C is ambiguous. `flag_amb` goes high, `sel` keeps its value, and `dout` comes from the held stream as in R4.
- R6: The stored previous bit is the `smp_ref` of the most recent valid bit. Invalid cycles do not change it.
- R7: `dout_vld` is `smp_vld` delayed by one cycle. A cycle with `smp_vld` low leaves `sel`, `dout` and `run_len` unchanged and drives all four flags low.
- R8: On valid bits, `run_len` counts consecutive no-transition bits. It saturates at 2^RUN_W-1 and clears to 0 on any valid bit that is not a no-transition bit.
- R9: Exactly one of the four flags is high whenever `dout_vld` is high.
- R10: After a phase step of the sampling clocks against the data, either between bursts or inside a burst, every recovered bit from the first bit that opens with a transition equals the transmitted bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | The four samples below are valid this cycle |
| smp_ref | input | 1 | Sample on the reference edge (current bit) |
| smp_mid | input | 1 | Sample at the expected transition opening the current bit |
| smp_pre | input | 1 | Sample a quarter bit before the reference edge |
| smp_post | input | 1 | Sample a quarter bit after the reference edge |
| dout | output | 1 | Recovered bit |
| dout_vld | output | 1 | `dout` and the flags carry a new bit |
| sel | output | 1 | Select register: 0 picks `smp_pre`, 1 picks `smp_post` |
| flag_early | output | 1 | Reference edge found early on this bit |
| flag_late | output | 1 | Reference edge found late on this bit |
| flag_idle | output | 1 | No transition on this bit |
| flag_amb | output | 1 | Transition seen but direction undecidable |
| run_len | output | RUN_W | Saturating count of consecutive no-transition bits |

## Verification
The hardest condition to reach from the ports is a sudden phase step that moves the reference edge across the bit centre while the select register still points at the wrong stream. In that state only a same-bit decision keeps the output correct. The bench builds a tick-level model of a transmitted bit waveform and derives all four samples of each bit from offsets around the bit centre. It then switches offsets from late to early and back, both in the middle of a burst and across idle gaps. It compares the recovered bits with the transmitted ones from the first transition onward. The ambiguous pattern never arises from a clean waveform, so it is driven as a direct sample vector.

// File: rtl/pp_pkg.sv
package pp_pkg;

  typedef enum logic [1:0] {
    DEC_IDLE  = 2'd0,
    DEC_LATE  = 2'd1,
    DEC_EARLY = 2'd2,
    DEC_AMB   = 2'd3
  } pp_dec_t;

  // prev = last bit, mid = crossing sample, cur = reference sample
  function automatic pp_dec_t pd_decide(input logic prev, input logic mid, input logic cur);
    logic x, y;
    x = mid ^ cur;
    y = prev ^ mid;
    case ({x, y})
      2'b01:   return DEC_LATE;
      2'b10:   return DEC_EARLY;
      2'b00:   return DEC_IDLE;
      default: return DEC_AMB;
    endcase
  endfunction

  // 0 = stream before centre, 1 = stream after centre
  function automatic logic sel_update(input pp_dec_t d, input logic cur_sel);
    case (d)
      DEC_LATE:  return 1'b0;
      DEC_EARLY: return 1'b1;
      default:   return cur_sel;
    endcase
  endfunction

  function automatic logic [15:0] sat_inc(input logic [15:0] v, input logic [15:0] max_v);
    return (v >= max_v) ? max_v : v + 16'd1;
  endfunction

endpackage

// File: rtl/pp_detect.sv
module pp_detect
  import pp_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    vld,
  input  logic    smp_mid,
  input  logic    smp_ref,
  output logic    prev_bit,
  output pp_dec_t dec
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst)      prev_q <= 1'b0;
    else if (vld) prev_q <= smp_ref;
  end

  assign prev_bit = prev_q;
  assign dec      = pd_decide(prev_q, smp_mid, smp_ref);

endmodule

// File: rtl/pp_select.sv
module pp_select
  import pp_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    vld,
  input  pp_dec_t dec,
  input  logic    smp_pre,
  input  logic    smp_post,
  output logic    sel_q,
  output logic    dout_q
);

  logic sel_nx;
  logic pick;

  assign sel_nx = sel_update(dec, sel_q);
  assign pick   = sel_nx ? smp_post : smp_pre;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= 1'b0;
      dout_q <= 1'b0;
    end else if (vld) begin
      sel_q  <= sel_nx;
      dout_q <= pick;
    end
  end

endmodule

// File: rtl/pp_runlen.sv
module pp_runlen
  import pp_pkg::*;
#(
  parameter int RUN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld,
  input  logic             idle,
  output logic [RUN_W-1:0] cnt
);

  localparam logic [15:0] MAX16 = 16'((1 << RUN_W) - 1);

  logic [15:0] wide_nx;

  assign wide_nx = sat_inc(16'(cnt), MAX16);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (vld)  cnt <= idle ? wide_nx[RUN_W-1:0] : '0;
  end

endmodule

// File: rtl/phase_pick_sel.sv
module phase_pick_sel
  import pp_pkg::*;
#(
  parameter int RUN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_vld,
  input  logic             smp_ref,
  input  logic             smp_mid,
  input  logic             smp_pre,
  input  logic             smp_post,
  output logic             dout,
  output logic             dout_vld,
  output logic             sel,
  output logic             flag_early,
  output logic             flag_late,
  output logic             flag_idle,
  output logic             flag_amb,
  output logic [RUN_W-1:0] run_len
);

  pp_dec_t dec_w;
  logic    prev_w;
  logic    idle_w;

  pp_detect u_det (
    .clk     (clk),
    .rst     (rst),
    .vld     (smp_vld),
    .smp_mid (smp_mid),
    .smp_ref (smp_ref),
    .prev_bit(prev_w),
    .dec     (dec_w)
  );

  pp_select u_sel (
    .clk     (clk),
    .rst     (rst),
    .vld     (smp_vld),
    .dec     (dec_w),
    .smp_pre (smp_pre),
    .smp_post(smp_post),
    .sel_q   (sel),
    .dout_q  (dout)
  );

  assign idle_w = (dec_w == DEC_IDLE);

  pp_runlen #(.RUN_W(RUN_W)) u_run (
    .clk (clk),
    .rst (rst),
    .vld (smp_vld),
    .idle(idle_w),
    .cnt (run_len)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_vld   <= 1'b0;
      flag_early <= 1'b0;
      flag_late  <= 1'b0;
      flag_idle  <= 1'b0;
      flag_amb   <= 1'b0;
    end else begin
      dout_vld   <= smp_vld;
      flag_early <= smp_vld && (dec_w == DEC_EARLY);
      flag_late  <= smp_vld && (dec_w == DEC_LATE);
      flag_idle  <= smp_vld && idle_w;
      flag_amb   <= smp_vld && (dec_w == DEC_AMB);
    end
  end

endmodule

// File: rtl/pp_chk.sv
module pp_chk #(
  parameter int RUN_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             smp_vld,
  input logic             smp_ref,
  input logic             prev_bit,
  input logic             dout_vld,
  input logic             sel,
  input logic             flag_early,
  input logic             flag_late,
  input logic             flag_idle,
  input logic             flag_amb,
  input logic [RUN_W-1:0] run_len
);

  localparam logic [RUN_W-1:0] RMAX = '1;

  // R7
  vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
    smp_vld |=> dout_vld);

  // R7
  vld_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !smp_vld |=> (!dout_vld && $stable(sel) && $stable(run_len)
                  && !flag_early && !flag_late && !flag_idle && !flag_amb));

  // R2
  late_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (dout_vld && flag_late) |-> !sel);

  // R3
  early_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (dout_vld && flag_early) |-> sel);

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dout_vld && flag_idle) |-> $stable(sel));

  // R5
  amb_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dout_vld && flag_amb) |-> $stable(sel));

  // R6
  prev_track_chk: assert property (@(posedge clk) disable iff (rst)
    smp_vld |=> (prev_bit == $past(smp_ref)));

  // R8
  run_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (dout_vld && !flag_idle) |-> (run_len == '0));

  // R8
  run_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (dout_vld && flag_idle && $past(run_len) == RMAX) |-> (run_len == RMAX));

  // R9
  flag_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    dout_vld |-> ($countones({flag_early, flag_late, flag_idle, flag_amb}) == 1));

endmodule

bind phase_pick_sel pp_chk #(.RUN_W(RUN_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .smp_vld   (smp_vld),
  .smp_ref   (smp_ref),
  .prev_bit  (prev_w),
  .dout_vld  (dout_vld),
  .sel       (sel),
  .flag_early(flag_early),
  .flag_late (flag_late),
  .flag_idle (flag_idle),
  .flag_amb  (flag_amb),
  .run_len   (run_len)
);

// File: tb/phase_pick_sel_tb_top.sv
module phase_pick_sel_tb_top;

  localparam int RUN_W = 4;
  localparam int RMAX  = (1 << RUN_W) - 1;
  localparam int TPB   = 8;   // ticks per bit in the waveform model

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_vld = 1'b0, smp_ref = 1'b0, smp_mid = 1'b0, smp_pre = 1'b0, smp_post = 1'b0;
  logic dout, dout_vld, sel, flag_early, flag_late, flag_idle, flag_amb;
  logic [RUN_W-1:0] run_len;

  int n_cmp = 0;
  int n_bad = 0;

  // behavioural model state
  int m_prev = 0, m_sel = 0, m_dout = 0, m_vld = 0, m_run = 0;
  int m_e = 0, m_l = 0, m_i = 0, m_a = 0;

  // waveform for the phase-step scenario
  int wave[$];

  always #4 clk = ~clk;

  phase_pick_sel #(.RUN_W(RUN_W)) dut_i (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_ref(smp_ref),
    .smp_mid(smp_mid), .smp_pre(smp_pre), .smp_post(smp_post),
    .dout(dout), .dout_vld(dout_vld), .sel(sel),
    .flag_early(flag_early), .flag_late(flag_late),
    .flag_idle(flag_idle), .flag_amb(flag_amb), .run_len(run_len)
  );

  task automatic cmp(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cmp_all(input string req);
    cmp(req, "dout_vld", int'(dout_vld), m_vld);
    cmp(req, "sel", int'(sel), m_sel);
    cmp(req, "dout", int'(dout), m_dout);
    cmp(req, "flag_early", int'(flag_early), m_e);
    cmp(req, "flag_late", int'(flag_late), m_l);
    cmp(req, "flag_idle", int'(flag_idle), m_i);
    cmp(req, "flag_amb", int'(flag_amb), m_a);
    cmp(req, "run_len", int'(run_len), m_run);
  endtask

  // apply one cycle of samples, advance the model, compare after the edge
  task automatic bit_step(input int v, input int pre, input int mid, input int cur,
                          input int post, input string req);
    bit edge_in, edge_out;
    @(negedge clk);
    smp_vld = v[0]; smp_pre = pre[0]; smp_mid = mid[0];
    smp_ref = cur[0]; smp_post = post[0];
    m_vld = v;
    m_e = 0; m_l = 0; m_i = 0; m_a = 0;
    if (v != 0) begin
      edge_in  = (m_prev != mid);
      edge_out = (mid != cur);
      if (edge_in && !edge_out)       begin m_l = 1; m_sel = 0; end
      else if (!edge_in && edge_out)  begin m_e = 1; m_sel = 1; end
      else if (!edge_in && !edge_out) m_i = 1;
      else                            m_a = 1;
      m_dout = (m_sel == 1) ? post : pre;
      m_run  = m_i ? ((m_run < RMAX) ? m_run + 1 : RMAX) : 0;
      m_prev = cur;
    end
    @(posedge clk);
    #1;
    cmp_all(req);
  endtask

  function automatic int wv(input int t);
    int idx;
    idx = (t < 0) ? 0 : t / TPB;
    if (idx >= wave.size()) idx = wave.size() - 1;
    return wave[idx];
  endfunction

  // one bit k of the waveform sampled with reference offset off ticks from centre
  task automatic wave_bit(input int k, input int off, input bit acq, output bit got_ok);
    int c;
    c = k * TPB + TPB / 2 + off;
    bit_step(1, wv(c - 2), wv(k * TPB + off), wv(c), wv(c + 2), "R10");
    got_ok = (int'(dout) == wave[k]);
    if (acq) begin
      n_cmp++;
      if (!got_ok) begin
        n_bad++;
        $display("FAIL R10 recovered bit %0d: actual=%0d expected=%0d", k, dout, wave[k]);
      end
    end
  endtask

  task automatic burst(input int k0, input int nbits, input int off);
    bit acq;
    bit ok;
    acq = 1'b0;
    for (int k = k0; k < k0 + nbits; k++) begin
      if (wave[k] != wave[k-1]) acq = 1'b1;
      wave_bit(k, off, acq, ok);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    cmp_all("R1");
    @(negedge clk);
    rst = 1'b0;

    // R2: prev=0, mid=1, ref=1 -> late, pick pre stream
    bit_step(1, 1, 1, 1, 0, "R2");
    // R3: prev=1, mid=1, ref=0 -> early, pick post stream
    bit_step(1, 1, 1, 0, 0, "R3");
    // R4: prev=0, all 0 -> idle, held sel=1 picks post
    bit_step(1, 0, 0, 0, 1, "R4");
    // R5: prev=0, mid=1, ref=0 -> ambiguous, held sel=1
    bit_step(1, 1, 1, 0, 0, "R5");
    // R7: invalid cycle with a would-be early pattern changes nothing
    bit_step(0, 1, 0, 1, 0, "R7");
    // R6: prev still 0 -> mid=0, ref=1 is early
    bit_step(1, 1, 0, 1, 0, "R6");
    // R2 again with post/pre differing
    bit_step(1, 0, 0, 0, 1, "R2");   // prev=1, mid=0 -> late
    // R8: long idle run saturates, then clears
    for (int i = 0; i < RMAX + 5; i++) bit_step(1, i % 2, 0, 0, (i + 1) % 2, "R8");
    bit_step(0, 0, 1, 1, 0, "R8");
    bit_step(1, 1, 0, 0, 1, "R8");
    bit_step(1, 1, 1, 1, 1, "R8");

    // R10: waveform-derived samples with phase steps
    wave.delete();
    for (int i = 0; i < 400; i++) wave.push_back(int'($urandom_range(0, 1)));
    burst(1, 40, 3);
    burst(41, 40, -3);      // step inside burst, late to early
    for (int g = 0; g < 3; g++) bit_step(0, 1, 0, 1, 0, "R7");
    burst(81, 50, -4);      // new burst, different phase
    burst(131, 40, 1);
    burst(171, 40, 0);
    for (int g = 0; g < 2; g++) bit_step(0, 0, 1, 0, 1, "R7");
    burst(211, 60, -1);
    burst(271, 60, 2);
    burst(331, 60, -2);

    @(negedge clk);
    smp_vld = 1'b0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule